// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes, called the global history. It also keeps a table indexed by the low bits of the branch address. Each table entry holds one small saturating counter for every possible history value. The history picks which counter in the addressed entry supplies the guess. Two branches at the same address can therefore be predicted differently, depending on how the branches just before them went.

The fetch side presents an address on the predict port and receives a one-bit guess in the same cycle, with no register on the path. When a branch resolves, the back end presents its address and real direction on the update port. At the next clock edge the block trains the counter that the current history selects in that entry, then shifts the outcome into the history.

Top module: `corr_branch_predictor`

## Requirements
- R1: `predTaken` is a combinational function of `predPc` and the stored state. The entry is chosen by `predPc[3:0]`, and within the entry the current 2-bit history chooses the counter.
- R2: Each counter is 2 bits wide: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. `predTaken` is the counter's bit 1.
- R3: An update with `updTaken`=1 adds one to the selected counter, stopping at 11. An update with `updTaken`=0 subtracts one, stopping at 00.
- R4: A counter at strong taken needs two not-taken updates before it predicts not-taken. One not-taken update still leaves the prediction at taken.
- R5: An update shifts `updTaken` into history bit 0, moves the old bit 0 into bit 1, and drops the old bit 1. History 01 means the older branch was not taken and the newer one was taken.
- R6: An update changes only the counter at entry `updPc[3:0]` that the pre-update history selects. The other three counters of that entry and all other entries keep their values.
- R7: In a cycle with `updValid`=0, no counter and no history bit changes.
- R8: After reset every counter is 01 and the history is 00, so every address predicts not-taken until the first update.
- R9: When a prediction and an update fall in the same cycle, the prediction reflects the state before that update.
- R10: Address bits above bit 3 have no effect on the prediction or on which entry is trained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | 32 | Address of the branch being predicted |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Actual direction of the resolved branch |

## Verification
Directed runs push one counter to strong taken under a steady all-taken history. They then interleave not-taken updates with updates at other addresses, which restores the history. This separates true two-miss hysteresis from a one-bit flip or a counter that wraps. Predictions at one address under all four history values show whether training spilled into neighbouring counters, and whether the history shifts in the stated direction. Addresses that differ only above bit 3, and updates that coincide with predictions at the same entry, test index aliasing and read-before-write ordering. A long seeded random mix of predictions, updates and idle cycles at few addresses is compared each cycle with a bench model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  parameter int CTR_W = 2;

  typedef struct packed {
    logic trainEn;    // write the selected counter this edge
    logic trainUp;    // direction of the counter step
    logic histShift;  // shift the outcome into the global history
  } bpStrobes_t;

  function automatic logic [CTR_W-1:0] satStep(input logic [CTR_W-1:0] cur,
                                              input logic up);
    logic [CTR_W-1:0] res;
    res = cur;
    if (up) begin
      if (cur != {CTR_W{1'b1}}) res = cur + 1'b1;
    end else begin
      if (cur != {CTR_W{1'b0}}) res = cur - 1'b1;
    end
    return res;
  endfunction
endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  output bpStrobes_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.trainEn   = updValid;
    strobes.histShift = updValid;
    strobes.trainUp   = updValid & updTaken;
  end
endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              bitIn,
  output logic [HIST_W-1:0] histQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        histQ <= '0;
    else if (shiftEn) histQ <= HIST_W'({histQ, bitIn});
  end
endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [HIST_W-1:0] hist,
  input  bpStrobes_t        strobes,
  output logic [CTR_W-1:0]  rdCtr
);
  localparam int SEL_W   = IDX_W + HIST_W;
  localparam int N_CTR   = 1 << SEL_W;
  localparam logic [CTR_W-1:0] WEAK_NT = (CTR_W'(1) << (CTR_W - 1)) - 1'b1;

  logic [CTR_W-1:0] ctrQ [N_CTR];
  logic [SEL_W-1:0] rdSel;
  logic [SEL_W-1:0] wrSel;

  assign rdSel = {rdIdx, hist};
  assign wrSel = {wrIdx, hist};

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrQ[i] <= WEAK_NT;
      else if (strobes.trainEn && (wrSel == SEL_W'(i)))
        ctrQ[i] <= satStep(ctrQ[i], strobes.trainUp);
    end
  end

  assign rdCtr = ctrQ[rdSel];
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);
  bpStrobes_t        strobes;
  logic [HIST_W-1:0] histQ;
  logic [CTR_W-1:0]  predCtr;

  bp_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .strobes  (strobes)
  );

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk     (clk),
    .rstN    (rstN),
    .shiftEn (strobes.histShift),
    .bitIn   (updTaken),
    .histQ   (histQ)
  );

  bp_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_table (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdx   (predPc[IDX_W-1:0]),
    .wrIdx   (updPc[IDX_W-1:0]),
    .hist    (histQ),
    .strobes (strobes),
    .rdCtr   (predCtr)
  );

  assign predTaken = predCtr[CTR_W-1];
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   predPc,
  input logic              predTaken,
  input logic              updValid,
  input logic              updTaken,
  input logic [HIST_W-1:0] histQ
);
  logic anyUpd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         anyUpd <= 1'b0;
    else if (updValid) anyUpd <= 1'b1;
  end

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histQ == HIST_W'({$past(histQ), $past(updTaken)}));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));

  // R7
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid ##1 $stable(predPc) |-> $stable(predTaken));

  // R8
  reset_pred_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyUpd |-> !predTaken);
endmodule

bind corr_branch_predictor bp_checker #(.PC_W(PC_W), .HIST_W(HIST_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .predPc    (predPc),
  .predTaken (predTaken),
  .updValid  (updValid),
  .updTaken  (updTaken),
  .histQ     (histQ)
);

// File: tb/corr_branch_predictor_test.sv
module corr_branch_predictor_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] predPc = '0;
  logic        predTaken;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] refCtr [64];
  logic [1:0] refHist;

  always #2 clk = ~clk;

  corr_branch_predictor uut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic logic refPred(input logic [31:0] pc);
    return refCtr[{pc[3:0], refHist}][1];
  endfunction

  function automatic logic [1:0] refStep(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic check(input string tag, input logic exp);
    checks++;
    if (predTaken !== exp) begin
      errors++;
      $display("FAIL %s pc=%h actual=%b expected=%b", tag, predPc, predTaken, exp);
    end
  endtask

  // one cycle: drive at falling edge, check before the rising edge, then advance the model
  task automatic step(input logic [31:0] pPc, input logic uV, input logic [31:0] uPc,
                      input logic uT, input string tag);
    @(negedge clk);
    predPc = pPc; updValid = uV; updPc = uPc; updTaken = uT;
    #1;
    check(tag, refPred(pPc));
    if (uV) begin
      refCtr[{uPc[3:0], refHist}] = refStep(refCtr[{uPc[3:0], refHist}], uT);
      refHist = {refHist[0], uT};
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) refCtr[i] = 2'b01;
    refHist = 2'b00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: every entry predicts not-taken out of reset
    for (int a = 0; a < 16; a++) step(32'(a), 1'b0, '0, 1'b0, "R8");
    // R5: taken on addr 2 moves history to 01; addr 2 now reads a fresh counter
    step(32'h2, 1'b1, 32'h2, 1'b1, "R5");
    step(32'h2, 1'b0, '0, 1'b0, "R5");
    // R3/R4: saturate addr 3 under history 11
    for (int k = 0; k < 6; k++) step(32'h3, 1'b1, 32'h3, 1'b1, "R3");
    step(32'h3, 1'b1, 32'h3, 1'b0, "R4");   // 11 -> 10, history 10
    step(32'h3, 1'b1, 32'h9, 1'b1, "R4");
    step(32'h3, 1'b1, 32'h9, 1'b1, "R4");   // history back at 11
    step(32'h3, 1'b0, '0, 1'b0, "R4");      // one miss: still taken
    step(32'h3, 1'b1, 32'h3, 1'b0, "R4");   // 10 -> 01, history 10
    step(32'h3, 1'b1, 32'h9, 1'b1, "R4");
    step(32'h3, 1'b1, 32'h9, 1'b1, "R4");
    step(32'h3, 1'b0, '0, 1'b0, "R4");      // two misses: not taken
    // R6: addr 3 under the other three histories
    step(32'h3, 1'b1, 32'h5, 1'b0, "R6");
    step(32'h3, 1'b1, 32'h5, 1'b0, "R6");
    step(32'h3, 1'b1, 32'h5, 1'b1, "R6");
    step(32'h3, 1'b0, '0, 1'b0, "R6");
    // R9: same entry predicted and trained together
    for (int k = 0; k < 4; k++) step(32'h6, 1'b1, 32'h6, 1'b1, "R9");
    // R10: high address bits alias onto the low index
    step(32'hABCD_0006, 1'b1, 32'h1234_5676, 1'b1, "R10");
    step(32'hFFFF_FFF6, 1'b0, '0, 1'b0, "R10");
    // R7: idle cycles change nothing
    for (int k = 0; k < 4; k++) step(32'h6, 1'b0, 32'h6, 1'b0, "R7");
    // R1/R2: seeded random mix over few addresses
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] pp, up;
      logic uv, ut;
      pp = {$urandom, 4'($urandom % 6)} ;
      up = {$urandom, 4'($urandom % 6)} ;
      uv = ($urandom % 4) != 0;
      ut = ($urandom % 3) != 0;
      step(pp, uv, up, ut, "R1");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule